// File: doc/BRIEF.md
# Power-up reset and boot sequencer

This block decides when a small processor core may leave reset and how it starts executing. It watches a power-good indication, an active-low reset pin and an emulator reset input, and it drives the core's reset together with the side effects reset must have. While the core is in reset, the stack pointers are forced to the empty state, every interrupt is masked, and the mode/status register is cleared. After a power-up, the core is held until the clock has had a fixed number of cycles to settle. A reset that arrives later skips that wait, but a pulse must last a minimum number of cycles before it counts.

When reset ends, the block checks the bus. If another master holds a bus request, the block waits for the request to drop. If boot mode is configured, the block then asserts a boot-loader request and keeps instruction fetch off until the loader reports completion. If boot mode is not configured, fetch starts directly. The first fetch always goes to address zero. A three-bit status output shows which phase the sequencer is in.

The power-good input acts on the core reset output at once, without waiting for a clock edge. The pin and the emulator input are combined and pass through a two-flop synchronizer before any decision is taken. The boot mode, bus request and boot-done inputs are assumed to be synchronous to the clock.

Top module: `rst_boot_seq`

## Requirements
- R1: After power-good rises, the core reset output stays low for at least STAB_CYCLES clock cycles, even if the reset pin was released earlier. The status output reads 1 (stabilizing) during that wait.
- R2: A reset pin pulse after power-up that is accepted releases the core no more than 4 cycles after the pin returns high. Status 1 (stabilizing) never appears on that path.
- R3: A pin low pulse shorter than MIN_PULSE cycles leaves the core reset output high and drives the glitch output high for exactly one cycle. A pulse of MIN_PULSE cycles or longer is accepted, with no glitch.
- R4: While the core reset output is low, the stack-empty, interrupt-mask and mode-clear outputs are all 1. While it is high, all three are 0.
- R5: When reset ends with boot mode set and no bus request, status reads 3 and the boot request output is 1. Fetch stays disabled until boot-done is seen, and then status reads 4 (running).
- R6: Whenever fetch is enabled, the fetch address is 0. With boot mode clear, fetch enable rises exactly one cycle after the core reset output rises.
- R7: A low pulse on the emulator reset input has the same effect as the same pulse on the reset pin, including the minimum-width rule.
- R8: If a bus request is pending when reset ends, the core leaves reset and status reads 2 (bus wait), with boot request and fetch enable both 0. Both stay 0 until the request drops.
- R9: Driving power-good low forces the core reset output low immediately, without a clock edge.
- R10: The status output encodes the phases as follows: 0 holding reset, 1 stabilizing, 2 bus wait, 3 booting, 4 running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all sequencing |
| por_n | input | 1 | Power-good indication; low means cold reset |
| rst_pin_n | input | 1 | Asynchronous active-low reset pin |
| emu_rst_n | input | 1 | Emulator reset input, active low, combined with the pin |
| boot_mode | input | 1 | 1 selects boot loading after reset |
| bus_req | input | 1 | Another master has a bus request pending |
| boot_done | input | 1 | Boot loader reports completion |
| core_rst_n | output | 1 | Active-low reset for the core |
| stk_empty | output | 1 | Force every stack pointer to empty |
| irq_mask | output | 1 | Mask all interrupts |
| mstat_clr | output | 1 | Clear the mode/status register |
| boot_start | output | 1 | Boot-loader request, held until boot_done |
| fetch_en | output | 1 | Instruction fetch allowed |
| fetch_addr | output | ADDR_W | First fetch address, always zero |
| glitch | output | 1 | One-cycle flag for a reset pulse that was too short |
| state_o | output | 3 | Sequencer phase, encoded as in R10 |

## Verification
The bench builds the block with STAB_CYCLES set to 32 and MIN_PULSE left at 4. The shorter settle window lets a cold reset be timed from end to end, and a second power cycle can be counted in a few dozen cycles while the counter keeps its saturating compare. With MIN_PULSE at 4, pulse lengths on both sides of the threshold are cheap to drive: 1, 2 and 3 cycles are rejected, and 4, 6 and 9 cycles are accepted. This puts the exact boundary of the pulse filter, the bus-wait hold and the boot handshake all within one short run.

// File: rtl/rbs_pkg.sv
// Shared types for the reset and boot sequencer.
// Assumes: the state encoding is visible on the status output and must not change.
package rbs_pkg;
    typedef enum logic [2:0] {
        ST_HOLD     = 3'd0,
        ST_STAB     = 3'd1,
        ST_WAIT_BUS = 3'd2,
        ST_BOOT     = 3'd3,
        ST_RUN      = 3'd4
    } rbs_state_e;
endpackage

// File: rtl/rbs_sync.sv
// Multi-stage synchronizer for a single bit.
// ASYNC=1 clears the chain asynchronously (power-good path).
// ASYNC=0 uses a synchronous active-low reset.
// Assumes: d may change at any time relative to clk.
module rbs_sync #(
    parameter int   STAGES  = 2,
    parameter bit   ASYNC   = 1'b0,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (ASYNC) begin : g_async
            // Shift the input along the chain; cleared at once by rst_n.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end else begin : g_sync
            // Shift the input along the chain; reset on the clock edge.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rbs_pulse_filter.sv
// Minimum pulse-width filter for the synchronized reset request.
// warm_hit goes high on the MIN_PULSE-th consecutive low sample.
// A low run that ends earlier raises glitch for one cycle.
// Assumes: pin_lo is already synchronous to clk.
module rbs_pulse_filter #(
    parameter int MIN_PULSE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_lo,
    output logic warm_hit,
    output logic glitch
);
    localparam int CW = $clog2(MIN_PULSE + 1);
    localparam logic [CW-1:0] CMAX = CW'(MIN_PULSE);
    localparam logic [CW-1:0] CHIT = CW'(MIN_PULSE - 1);

    logic [CW-1:0] run_cnt;

    // Count consecutive low samples and flag runs that end too early.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            glitch  <= 1'b0;
        end else begin
            glitch <= !pin_lo && (run_cnt != '0) && (run_cnt < CMAX);
            if (pin_lo) run_cnt <= (run_cnt == CMAX) ? run_cnt : run_cnt + 1'b1;
            else        run_cnt <= '0;
        end
    end

    // The request counts once the run has reached the minimum width.
    always_comb warm_hit = pin_lo && (run_cnt >= CHIT);

    // R3: the glitch flag never lasts longer than one cycle.
    assert_glitch_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        glitch |=> !glitch);
endmodule

// File: rtl/rbs_ctrl.sv
// Phase controller: cold settle count, warm hold, bus wait, boot handshake, run.
// Assumes: boot_mode, bus_req and boot_done are synchronous to clk.
// Assumes: rst_n stays low until power is good.
module rbs_ctrl
    import rbs_pkg::*;
#(
    parameter int STAB_CYCLES = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_lo,
    input  logic       warm_hit,
    input  logic       boot_mode,
    input  logic       bus_req,
    input  logic       boot_done,
    output rbs_state_e state,
    output logic       in_rst,
    output logic       boot_req,
    output logic       fetch_en
);
    localparam int SW = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;
    localparam logic [SW-1:0] SLAST = SW'(STAB_CYCLES - 1);

    rbs_state_e      st_q, st_d, rel_target;
    logic [SW-1:0]   stab_cnt;
    logic            cold_q, fetch_q, stab_done;

    // Pick where the sequencer goes once reset ends.
    always_comb begin
        if (bus_req)        rel_target = ST_WAIT_BUS;
        else if (boot_mode) rel_target = ST_BOOT;
        else                rel_target = ST_RUN;
    end

    assign stab_done = (stab_cnt == SLAST);

    // Next-phase decision, with accepted warm resets taking priority.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HOLD:     if (cold_q) st_d = ST_STAB;
                         else if (!pin_lo) st_d = rel_target;
            ST_STAB:     if (stab_done && !pin_lo) st_d = rel_target;
            ST_WAIT_BUS: if (!bus_req) st_d = boot_mode ? ST_BOOT : ST_RUN;
            ST_BOOT:     if (boot_done) st_d = ST_RUN;
            ST_RUN:      st_d = ST_RUN;
            default:     st_d = ST_HOLD;
        endcase
        if (warm_hit && (st_q == ST_WAIT_BUS || st_q == ST_BOOT || st_q == ST_RUN))
            st_d = ST_HOLD;
    end

    // Phase register plus the cold-start marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_HOLD;
            cold_q <= 1'b1;
        end else begin
            st_q <= st_d;
            if (st_q == ST_STAB && st_d != ST_STAB) cold_q <= 1'b0;
        end
    end

    // Settle counter: runs only while stabilizing and saturates at the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || st_q != ST_STAB) stab_cnt <= '0;
        else if (!stab_done)           stab_cnt <= stab_cnt + 1'b1;
    end

    // Delay fetch by one cycle after entering the run phase.
    always_ff @(posedge clk) begin
        if (!rst_n) fetch_q <= 1'b0;
        else        fetch_q <= (st_q == ST_RUN);
    end

    assign state    = st_q;
    assign in_rst   = (st_q == ST_HOLD) || (st_q == ST_STAB);
    assign boot_req = (st_q == ST_BOOT);
    assign fetch_en = fetch_q && (st_q == ST_RUN);

    // R1: the settle phase is left only after the full count.
    assert_stab_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q) == ST_STAB && st_q != ST_STAB) |-> $past(stab_cnt) == SLAST);
    // R2: only a cold start can be in the settle phase.
    assert_warm_no_stab_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STAB) |-> cold_q);
    // R5: no fetch while the boot loader runs.
    assert_boot_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        boot_req |-> !fetch_en);
    // R6: fetch never starts while the core is still in reset.
    assert_fetch_out_of_rst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_rst |-> !fetch_en);
    // R8: the bus-wait phase only persists while a request was present.
    assert_bus_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT_BUS) |-> $past(bus_req));
endmodule

// File: rtl/rst_boot_seq.sv
// Top level of the reset and boot sequencer.
// Combines the pin and emulator resets, synchronizes them, filters short
// pulses, and sequences the core through settle, bus wait, boot and run.
// Assumes: por_n low acts on core_rst_n at once; everything else is clocked.
module rst_boot_seq
    import rbs_pkg::*;
#(
    parameter int          STAB_CYCLES = 2000,
    parameter int          MIN_PULSE   = 4,
    parameter int          SYNC_STAGES = 2,
    parameter int          ADDR_W      = 14,
    parameter logic [13:0] RESET_VEC   = 14'h0000
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_pin_n,
    input  logic              emu_rst_n,
    input  logic              boot_mode,
    input  logic              bus_req,
    input  logic              boot_done,
    output logic              core_rst_n,
    output logic              stk_empty,
    output logic              irq_mask,
    output logic              mstat_clr,
    output logic              boot_start,
    output logic              fetch_en,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              glitch,
    output logic [2:0]        state_o
);
    logic       por_ok, req_n, pin_s, pin_lo, warm_hit, in_rst;
    rbs_state_e st;

    // Pin and emulator reset form a single request.
    assign req_n = rst_pin_n & emu_rst_n;

    rbs_sync #(.STAGES(SYNC_STAGES), .ASYNC(1'b1), .RST_VAL(1'b0)) u_por_sync (
        .clk(clk), .rst_n(por_n), .d(1'b1), .q(por_ok)
    );

    rbs_sync #(.STAGES(SYNC_STAGES), .ASYNC(1'b0), .RST_VAL(1'b1)) u_pin_sync (
        .clk(clk), .rst_n(por_ok), .d(req_n), .q(pin_s)
    );

    assign pin_lo = !pin_s;

    rbs_pulse_filter #(.MIN_PULSE(MIN_PULSE)) u_filter (
        .clk(clk), .rst_n(por_ok), .pin_lo(pin_lo),
        .warm_hit(warm_hit), .glitch(glitch)
    );

    rbs_ctrl #(.STAB_CYCLES(STAB_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(por_ok), .pin_lo(pin_lo), .warm_hit(warm_hit),
        .boot_mode(boot_mode), .bus_req(bus_req), .boot_done(boot_done),
        .state(st), .in_rst(in_rst), .boot_req(boot_start), .fetch_en(fetch_en)
    );

    // Power-good acts without a clock; the phase controller does the rest.
    assign core_rst_n = por_n & !in_rst;
    assign stk_empty  = !core_rst_n;
    assign irq_mask   = !core_rst_n;
    assign mstat_clr  = !core_rst_n;
    assign fetch_addr = ADDR_W'(RESET_VEC);
    assign state_o    = st;

    // R3: a rejected pulse never takes the running core into reset.
    assert_glitch_no_rst_R3: assert property (@(posedge clk) disable iff (!por_ok)
        (glitch && $past(core_rst_n)) |-> core_rst_n);
    // R8: while waiting for the bus, neither boot nor fetch is active.
    assert_bus_quiet_R8: assert property (@(posedge clk) disable iff (!por_ok)
        (state_o == 3'd2) |-> (!boot_start && !fetch_en && core_rst_n));
endmodule

// File: tb/test_rst_boot_seq.sv
module test_rst_boot_seq;
    localparam int STAB = 32;
    localparam int MINP = 4;
    localparam int AW   = 14;

    // Vector table: pulse length, boot mode, expected acceptance.
    localparam int VEC_N = 6;
    localparam int V_LEN [VEC_N] = '{3, 4, 1, 6, 2, 9};
    localparam bit V_BOOT[VEC_N] = '{0, 0, 0, 1, 1, 0};
    localparam bit V_ACC [VEC_N] = '{0, 1, 0, 1, 0, 1};

    logic clk = 1'b0;
    logic por_n, rst_pin_n, emu_rst_n, boot_mode, bus_req, boot_done;
    logic core_rst_n, stk_empty, irq_mask, mstat_clr, boot_start, fetch_en, glitch;
    logic [AW-1:0] fetch_addr;
    logic [2:0] state_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rst_boot_seq #(.STAB_CYCLES(STAB), .MIN_PULSE(MINP), .ADDR_W(AW)) i_rst_boot_seq (
        .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .emu_rst_n(emu_rst_n),
        .boot_mode(boot_mode), .bus_req(bus_req), .boot_done(boot_done),
        .core_rst_n(core_rst_n), .stk_empty(stk_empty), .irq_mask(irq_mask),
        .mstat_clr(mstat_clr), .boot_start(boot_start), .fetch_en(fetch_en),
        .fetch_addr(fetch_addr), .glitch(glitch), .state_o(state_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Watch n cycles: reset cycles, last low index, glitch cycles, settle seen.
    task automatic observe(input int n, output int rc, output int last_lo,
                           output int gl, output bit saw_stab);
        rc = 0; last_lo = 0; gl = 0; saw_stab = 0;
        for (int i = 1; i <= n; i++) begin
            cyc(1);
            if (!core_rst_n) begin rc++; last_lo = i; end
            if (glitch) gl++;
            if (state_o == 3'd1) saw_stab = 1;
        end
    endtask

    task automatic count_release(output int n);
        n = 0;
        while (!core_rst_n && n < 500) begin cyc(1); n++; end
    endtask

    task automatic run_all();
        int rc, lo, gl, n;
        bit ss;
        por_n = 0; rst_pin_n = 1; emu_rst_n = 1;
        boot_mode = 0; bus_req = 0; boot_done = 0;
        #1;
        chk(core_rst_n == 0, "R9 reset before any clock", core_rst_n, 0);
        chk(stk_empty && irq_mask && mstat_clr, "R4 reset side effects", stk_empty, 1);

        // R1: cold start, pin released well before the settle count ends.
        cyc(3);
        por_n = 1; rst_pin_n = 0;
        cyc(6);
        rst_pin_n = 1;
        cyc(4);
        chk(state_o == 3'd1, "R1 settle phase shown", state_o, 1);
        chk(core_rst_n == 0, "R1 held during settle", core_rst_n, 0);
        count_release(n);
        chk(n + 10 >= STAB, "R1 minimum hold", n + 10, STAB);
        chk(n + 10 <= STAB + 8, "R1 release reached", n + 10, STAB + 8);
        chk(fetch_en == 0, "R6 no fetch on release cycle", fetch_en, 0);
        chk(!stk_empty && !irq_mask && !mstat_clr, "R4 side effects off", stk_empty, 0);
        cyc(1);
        chk(fetch_en == 1, "R6 fetch one cycle later", fetch_en, 1);
        chk(fetch_addr == 0, "R6 fetch address", fetch_addr, 0);
        chk(state_o == 3'd4, "R10 running code", state_o, 4);

        // Table of warm pulses around the minimum width.
        for (int v = 0; v < VEC_N; v++) begin
            boot_mode = V_BOOT[v];
            rst_pin_n = 0;
            cyc(V_LEN[v]);
            rst_pin_n = 1;
            observe(10, rc, lo, gl, ss);
            if (V_ACC[v]) begin
                chk(rc > 0, "R3 long pulse accepted", rc, 1);
                chk(gl == 0, "R3 no glitch on accepted pulse", gl, 0);
                chk(lo <= 4, "R2 warm release latency", lo, 4);
                chk(!ss, "R2 no settle on warm reset", ss, 0);
            end else begin
                chk(rc == 0, "R3 short pulse ignored", rc, 0);
                chk(gl == 1, "R3 single glitch cycle", gl, 1);
            end
            if (V_ACC[v] && V_BOOT[v]) begin
                chk(state_o == 3'd3, "R5 boot phase", state_o, 3);
                chk(boot_start == 1, "R5 boot request held", boot_start, 1);
                chk(fetch_en == 0, "R5 fetch gated in boot", fetch_en, 0);
                boot_done = 1; cyc(1); boot_done = 0;
                cyc(2);
            end
            chk(state_o == 3'd4, "R5 run after sequence", state_o, 4);
            chk(fetch_en == 1, "R6 fetch enabled", fetch_en, 1);
            chk(fetch_addr == 0, "R6 fetch address zero", fetch_addr, 0);
            boot_mode = 0;
        end

        // R4: held warm reset drives the side-effect outputs.
        rst_pin_n = 0;
        cyc(8);
        chk(core_rst_n == 0 && state_o == 3'd0, "R4 warm hold", state_o, 0);
        chk(stk_empty && irq_mask && mstat_clr, "R4 outputs during hold", mstat_clr, 1);
        rst_pin_n = 1;
        cyc(6);
        chk(core_rst_n && !stk_empty && !irq_mask && !mstat_clr, "R4 outputs after hold",
            stk_empty, 0);

        // R7: emulator reset follows the same rules as the pin.
        emu_rst_n = 0; cyc(6); emu_rst_n = 1;
        observe(10, rc, lo, gl, ss);
        chk(rc > 0 && gl == 0, "R7 emulator reset accepted", rc, 1);
        emu_rst_n = 0; cyc(2); emu_rst_n = 1;
        observe(10, rc, lo, gl, ss);
        chk(rc == 0 && gl == 1, "R7 short emulator pulse filtered", gl, 1);

        // R8: bus request pending at release, then boot.
        boot_mode = 1; bus_req = 1;
        rst_pin_n = 0; cyc(6); rst_pin_n = 1;
        cyc(8);
        chk(state_o == 3'd2, "R8 bus wait phase", state_o, 2);
        chk(core_rst_n == 1, "R8 core out of reset", core_rst_n, 1);
        chk(!boot_start && !fetch_en, "R8 boot and fetch held", boot_start, 0);
        cyc(5);
        chk(state_o == 3'd2 && !boot_start, "R8 still waiting", state_o, 2);
        bus_req = 0;
        cyc(2);
        chk(state_o == 3'd3 && boot_start, "R8 boot after bus drops", state_o, 3);
        boot_done = 1; cyc(1); boot_done = 0;
        cyc(2);
        chk(state_o == 3'd4 && fetch_en && fetch_addr == 0, "R5 fetch after boot", state_o, 4);
        boot_mode = 0;

        // R9 and R1: a second power cycle.
        por_n = 0;
        #1;
        chk(core_rst_n == 0, "R9 immediate power reset", core_rst_n, 0);
        cyc(3);
        por_n = 1;
        count_release(n);
        chk(n >= STAB, "R1 second cold start hold", n, STAB);
        chk(state_o == 3'd4, "R1 run after second cold start", state_o, 4);
    endtask

    initial begin
        fork
            begin run_all(); end
            begin
                repeat (50000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule